// File: doc/BRIEF.md
# Four-Channel Memory-to-Memory Transfer Engine

This block copies runs of data units from one address range to another on a simple single-master memory bus. Four channels are each programmed through a small word-addressed register window. For each channel software sets a source address, a destination address, a unit count, a unit width, the trigger that starts the channel, and the way the channel holds the bus. A single engine serves one channel at a time. Each unit is one read followed by one write, and the written value is the read value cut to the unit width.

A channel can be started by a software go bit or by a level on its external request pin. When several channels ask for the bus at once, an arbiter picks one. It uses either ascending channel order or a rotating order, set by one global bit. A channel in burst mode keeps the bus until its count is used up. A channel in cycle-steal mode gives the bus back after every unit and has to win arbitration again. When a channel finishes, it turns itself off, sets a sticky done flag and can raise its own interrupt line.

Register window (word address `reg_addr`): the top bit selects the global register, where bit 0 is the rotation enable. Otherwise the middle bits pick the channel and the two low bits pick the register: 0 source, 1 destination, 2 count, 3 control. Control bits: 0 enable, 1 software go, 2 external trigger select, 3 burst, 5:4 width (0 = 8-bit, 1 = 16-bit, 2 = 32-bit, 3 is stored as 32-bit), 6 hold source, 7 hold destination, 8 interrupt enable, 9 done (read 1 when finished; writing 1 clears it).

Top module: `dma_ctrl`

## Requirements
- R1: After reset every channel register, the done flags, the rotation bit, `reg_rdata`, `mem_req`, `ext_ack`, `irq` and `bus_busy` all read zero.
- R2: A channel with control bits 0 and 1 set and bit 2 clear starts. For each unit, the engine reads the current source address and then writes the value it read to the current destination address. `bus_ch` gives the serving channel number during both accesses.
- R3: Width code 0, 1 or 2 drives `mem_size` with that code. The written data is the read data masked to 8, 16 or 32 bits.
- R4: After each unit, the source and destination addresses each advance by 1, 2 or 4 bytes, matching the width code.
- R5: Control bit 6 keeps the source address fixed for the whole run. Bit 7 does the same for the destination address.
- R6: A count of N from 1 to 65535 moves exactly N units. A count of 0 moves 65536 units and reads back as 0 before the start.
- R7: After the last unit the channel clears its enable and go bits and sets done. `irq` for that channel rises only when bit 8 is set. Writing control with bit 9 set clears done, and `irq` then falls.
- R8: With the rotation bit at 0, every arbitration grants the lowest-numbered requesting channel.
- R9: With the rotation bit at 1, the channel granted last has the lowest priority at the next arbitration, so two channels that keep requesting alternate unit by unit.
- R10: In cycle-steal mode (bit 3 clear), `mem_req` drops for at least one cycle after every unit. In burst mode, the next read follows the write acknowledge with no gap until the count is used up.
- R11: With bit 2 set, the channel moves nothing while its `ext_req` line is low. `ext_ack` of that channel pulses high for exactly one cycle per unit moved.
- R12: Once `mem_req` is raised, it stays high with `mem_addr` and `mem_we` unchanged until a cycle in which `mem_ack` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data of `reg_addr` |
| ext_req | input | 4 | Level-sensitive external trigger, one per channel |
| ext_ack | output | 4 | One-cycle pulse per unit moved for an externally triggered channel |
| irq | output | 4 | Completion interrupt, one per channel |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | 32 | Byte address of the access |
| mem_size | output | 2 | Width code of the access |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid while `mem_ack` is high |
| mem_ack | input | 1 | Access completes in this cycle |
| bus_busy | output | 1 | Engine owns the bus |
| bus_ch | output | 2 | Channel that owns the bus |

## Verification
The bench uses the default parameters: four channels, a 16-bit count and 32-bit addresses and data. With a 16-bit count, the 65536-unit wrap of a zero count can be reached in a single burst run of about 131 thousand cycles, so R6 is checked at its real limit and not on a shortened counter. Four channels are enough to test ascending-order and rotating arbitration between two live requesters, while a third channel runs the stalled-bus test on its own.

// File: rtl/dma_pkg.sv
package dma_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } unit_size_e;

  // bit 0 is the LSB (enable), bit 8 the MSB (interrupt enable)
  typedef struct packed {
    logic       irq_en;
    logic       dst_hold;
    logic       src_hold;
    unit_size_e size;
    logic       burst;
    logic       ext_sel;
    logic       sw_go;
    logic       enable;
  } chan_ctrl_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } eng_state_e;

endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [1:0]    wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic          step,
  output logic [AW-1:0] src,
  output logic [AW-1:0] dst,
  output logic [CW:0]   remain,
  output chan_ctrl_t    ctrl,
  output logic          done,
  output logic          irq
);

  logic [AW-1:0] inc;
  logic [CW:0]   cnt_load;
  chan_ctrl_t    ctrl_wr;
  logic          last_unit;

  always_comb begin
    inc       = AW'(1) << ctrl.size;
    cnt_load  = (wr_data[CW-1:0] == '0) ? {1'b1, {CW{1'b0}}} : {1'b0, wr_data[CW-1:0]};
    ctrl_wr   = chan_ctrl_t'(wr_data[8:0]);
    if (ctrl_wr.size == SZ_RSVD) ctrl_wr.size = SZ_WORD;
    last_unit = (remain == {{CW{1'b0}}, 1'b1});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      src    <= '0;
      dst    <= '0;
      remain <= '0;
      ctrl   <= '0;
      done   <= 1'b0;
      irq    <= 1'b0;
    end else begin
      if (wr_en) begin
        case (wr_idx)
          2'd0:    src    <= wr_data[AW-1:0];
          2'd1:    dst    <= wr_data[AW-1:0];
          2'd2:    remain <= cnt_load;
          default: begin
            ctrl <= ctrl_wr;
            if (wr_data[9]) done <= 1'b0;
          end
        endcase
      end
      // engine progress overrides a same-cycle register write
      if (step) begin
        if (!ctrl.src_hold) src <= src + inc;
        if (!ctrl.dst_hold) dst <= dst + inc;
        remain <= remain - 1'b1;
        if (last_unit) begin
          ctrl.enable <= 1'b0;
          ctrl.sw_go  <= 1'b0;
          done        <= 1'b1;
        end
      end
      irq <= done & ctrl.irq_en;
    end
  end

endmodule

// File: rtl/dma_arbiter.sv
module dma_arbiter #(
  parameter int NCH = 4
) (
  input  logic [NCH-1:0]         req,
  input  logic                   rr_mode,
  input  logic [$clog2(NCH)-1:0] last,
  output logic                   valid,
  output logic [$clog2(NCH)-1:0] gnt
);

  localparam int IW = $clog2(NCH);

  int idx_c;

  // scan from lowest priority to highest so the highest one is assigned last
  always_comb begin
    valid = 1'b0;
    gnt   = '0;
    idx_c = 0;
    for (int k = NCH - 1; k >= 0; k--) begin
      idx_c = rr_mode ? (int'(last) + 1 + k) : k;
      if (idx_c >= NCH) idx_c = idx_c - NCH;
      if (req[idx_c]) begin
        valid = 1'b1;
        gnt   = IW'(idx_c);
      end
    end
  end

endmodule

// File: rtl/dma_engine.sv
module dma_engine
  import dma_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 32,
  parameter int DW  = 32
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NCH-1:0]         pend,
  input  logic                   rr_mode,
  input  logic [AW-1:0]          src_a   [NCH],
  input  logic [AW-1:0]          dst_a   [NCH],
  input  unit_size_e             size_a  [NCH],
  input  logic [NCH-1:0]         burst_v,
  input  logic [NCH-1:0]         src_hold_v,
  input  logic [NCH-1:0]         ext_sel_v,
  input  logic [NCH-1:0]         final_v,
  input  logic [NCH-1:0]         ext_req,
  output logic [NCH-1:0]         step,
  output logic                   mem_req,
  output logic                   mem_we,
  output logic [AW-1:0]          mem_addr,
  output logic [1:0]             mem_size,
  output logic [DW-1:0]          mem_wdata,
  input  logic [DW-1:0]          mem_rdata,
  input  logic                   mem_ack,
  output logic [NCH-1:0]         ext_ack,
  output logic                   bus_busy,
  output logic [$clog2(NCH)-1:0] bus_ch
);

  localparam int CHW = $clog2(NCH);

  eng_state_e     state;
  logic [CHW-1:0] last_q;
  logic           gnt_valid;
  logic [CHW-1:0] gnt_idx;
  logic [DW-1:0]  lane_mask;
  logic [AW-1:0]  next_src;
  logic           keep_bus;

  dma_arbiter #(.NCH(NCH)) u_arb (
    .req     (pend),
    .rr_mode (rr_mode),
    .last    (last_q),
    .valid   (gnt_valid),
    .gnt     (gnt_idx)
  );

  always_comb begin
    case (mem_size)
      2'd0:    lane_mask = DW'(8'hFF);
      2'd1:    lane_mask = DW'(16'hFFFF);
      default: lane_mask = '1;
    endcase
    next_src = src_hold_v[bus_ch] ? src_a[bus_ch]
                                  : src_a[bus_ch] + (AW'(1) << size_a[bus_ch]);
    keep_bus = burst_v[bus_ch] && !final_v[bus_ch] &&
               (ext_sel_v[bus_ch] ? ext_req[bus_ch] : 1'b1);
    step = '0;
    if (state == ST_WRITE && mem_ack) step[bus_ch] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      last_q    <= CHW'(NCH - 1);
      bus_ch    <= '0;
      bus_busy  <= 1'b0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_size  <= 2'd0;
      mem_wdata <= '0;
      ext_ack   <= '0;
    end else begin
      ext_ack <= '0;
      case (state)
        ST_IDLE: begin
          if (gnt_valid) begin
            bus_ch   <= gnt_idx;
            last_q   <= gnt_idx;
            bus_busy <= 1'b1;
            mem_req  <= 1'b1;
            mem_we   <= 1'b0;
            mem_addr <= src_a[gnt_idx];
            mem_size <= size_a[gnt_idx];
            state    <= ST_READ;
          end
        end
        ST_READ: begin
          if (mem_ack) begin
            mem_wdata <= mem_rdata & lane_mask;
            mem_we    <= 1'b1;
            mem_addr  <= dst_a[bus_ch];
            state     <= ST_WRITE;
          end
        end
        ST_WRITE: begin
          if (mem_ack) begin
            ext_ack[bus_ch] <= ext_sel_v[bus_ch];
            mem_we          <= 1'b0;
            if (keep_bus) begin
              mem_addr <= next_src;
              state    <= ST_READ;
            end else begin
              mem_req  <= 1'b0;
              bus_busy <= 1'b0;
              state    <= ST_IDLE;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/dma_ctrl.sv
module dma_ctrl
  import dma_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 32,
  parameter int DW  = 32,
  parameter int CW  = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     reg_wr,
  input  logic [$clog2(NCH)+2:0]   reg_addr,
  input  logic [DW-1:0]            reg_wdata,
  output logic [DW-1:0]            reg_rdata,
  input  logic [NCH-1:0]           ext_req,
  output logic [NCH-1:0]           ext_ack,
  output logic [NCH-1:0]           irq,
  output logic                     mem_req,
  output logic                     mem_we,
  output logic [AW-1:0]            mem_addr,
  output logic [1:0]               mem_size,
  output logic [DW-1:0]            mem_wdata,
  input  logic [DW-1:0]            mem_rdata,
  input  logic                     mem_ack,
  output logic                     bus_busy,
  output logic [$clog2(NCH)-1:0]   bus_ch
);

  localparam int CHW = $clog2(NCH);
  localparam int RAW = CHW + 3;

  logic           glob_sel;
  logic [CHW-1:0] ch_sel;
  logic [1:0]     idx_sel;
  logic           rr_mode;
  logic [DW-1:0]  rd_next;

  logic [AW-1:0]  src_a    [NCH];
  logic [AW-1:0]  dst_a    [NCH];
  logic [CW:0]    remain_a [NCH];
  chan_ctrl_t     ctrl_a   [NCH];
  unit_size_e     size_a   [NCH];
  logic [NCH-1:0] done_v;
  logic [NCH-1:0] pend;
  logic [NCH-1:0] burst_v;
  logic [NCH-1:0] src_hold_v;
  logic [NCH-1:0] ext_sel_v;
  logic [NCH-1:0] final_v;
  logic [NCH-1:0] unit_step;

  assign glob_sel = reg_addr[RAW-1];
  assign ch_sel   = reg_addr[RAW-2:2];
  assign idx_sel  = reg_addr[1:0];

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    dma_chan_regs #(.AW(AW), .DW(DW), .CW(CW)) u_regs (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (reg_wr && !glob_sel && (ch_sel == CHW'(c))),
      .wr_idx  (idx_sel),
      .wr_data (reg_wdata),
      .step    (unit_step[c]),
      .src     (src_a[c]),
      .dst     (dst_a[c]),
      .remain  (remain_a[c]),
      .ctrl    (ctrl_a[c]),
      .done    (done_v[c]),
      .irq     (irq[c])
    );
    assign size_a[c]     = ctrl_a[c].size;
    assign burst_v[c]    = ctrl_a[c].burst;
    assign src_hold_v[c] = ctrl_a[c].src_hold;
    assign ext_sel_v[c]  = ctrl_a[c].ext_sel;
    assign final_v[c]    = (remain_a[c] == {{CW{1'b0}}, 1'b1});
    assign pend[c]       = ctrl_a[c].enable &
                           (ctrl_a[c].ext_sel ? ext_req[c] : ctrl_a[c].sw_go);
  end

  dma_engine #(.NCH(NCH), .AW(AW), .DW(DW)) u_eng (
    .clk        (clk),
    .rst        (rst),
    .pend       (pend),
    .rr_mode    (rr_mode),
    .src_a      (src_a),
    .dst_a      (dst_a),
    .size_a     (size_a),
    .burst_v    (burst_v),
    .src_hold_v (src_hold_v),
    .ext_sel_v  (ext_sel_v),
    .final_v    (final_v),
    .ext_req    (ext_req),
    .step       (unit_step),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_size   (mem_size),
    .mem_wdata  (mem_wdata),
    .mem_rdata  (mem_rdata),
    .mem_ack    (mem_ack),
    .ext_ack    (ext_ack),
    .bus_busy   (bus_busy),
    .bus_ch     (bus_ch)
  );

  always_comb begin
    rd_next = '0;
    if (glob_sel) begin
      rd_next[0] = rr_mode;
    end else begin
      case (idx_sel)
        2'd0:    rd_next[AW-1:0] = src_a[ch_sel];
        2'd1:    rd_next[AW-1:0] = dst_a[ch_sel];
        2'd2:    rd_next[CW-1:0] = remain_a[ch_sel][CW-1:0];
        default: rd_next[9:0]    = {done_v[ch_sel], ctrl_a[ch_sel]};
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rr_mode   <= 1'b0;
      reg_rdata <= '0;
    end else begin
      if (reg_wr && glob_sel) rr_mode <= reg_wdata[0];
      reg_rdata <= rd_next;
    end
  end

endmodule

// File: rtl/dma_ctrl_chk.sv
module dma_ctrl_chk #(
  parameter int NCH = 4,
  parameter int AW  = 32
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   mem_req,
  input logic                   mem_we,
  input logic                   mem_ack,
  input logic [AW-1:0]          mem_addr,
  input logic [NCH-1:0]         ext_ack,
  input logic [NCH-1:0]         unit_step,
  input logic [NCH-1:0]         burst_v,
  input logic                   bus_busy,
  input logic [$clog2(NCH)-1:0] bus_ch
);

  a_r12_hold_until_ack: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  a_r12_req_owned: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> bus_busy);

  a_r2_write_after_read: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we) |-> $past(mem_req && mem_ack && !mem_we));

  a_r2_single_channel_step: assert property (@(posedge clk) disable iff (rst)
    $onehot0(unit_step));

  a_r10_steal_releases: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we && mem_ack && !burst_v[bus_ch]) |=> !mem_req);

  a_r11_ack_one_line: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ext_ack));

  a_r11_ack_one_cycle: assert property (@(posedge clk) disable iff (rst)
    (|ext_ack) |=> !(|ext_ack));

endmodule

bind dma_ctrl dma_ctrl_chk #(.NCH(NCH), .AW(AW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_ack   (mem_ack),
  .mem_addr  (mem_addr),
  .ext_ack   (ext_ack),
  .unit_step (unit_step),
  .burst_v   (burst_v),
  .bus_busy  (bus_busy),
  .bus_ch    (bus_ch)
);

// File: tb/tb_dma_ctrl.sv
module tb_dma_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int WD_CYC     = 195000;
  localparam int NV         = 6;

  // {ch[86:85], size[84:83], src_hold[82], dst_hold[81], burst[80], cnt[79:64], src[63:32], dst[31:0]}
  localparam logic [86:0] VEC [NV] = '{
    {2'd0, 2'd2, 1'b0, 1'b0, 1'b1, 16'd4, 32'h0000_1000, 32'h0000_2000},
    {2'd1, 2'd0, 1'b0, 1'b0, 1'b0, 16'd5, 32'h0000_3001, 32'h0000_4003},
    {2'd2, 2'd1, 1'b1, 1'b0, 1'b1, 16'd3, 32'h0000_5000, 32'h0000_6000},
    {2'd3, 2'd2, 1'b0, 1'b1, 1'b0, 16'd2, 32'h0000_7100, 32'h0000_8100},
    {2'd0, 2'd1, 1'b0, 1'b0, 1'b1, 16'd1, 32'h0000_9002, 32'h0000_A00E},
    {2'd3, 2'd0, 1'b1, 1'b1, 1'b1, 16'd6, 32'h0000_B005, 32'h0000_C007}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [3:0]  ext_req = '0;
  logic [3:0]  ext_ack;
  logic [3:0]  irq;
  logic        mem_req, mem_we, mem_ack, bus_busy;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [1:0]  mem_size, bus_ch;
  logic        ack_gate = 1'b1;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic [31:0] mdl(input logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
  endfunction

  function automatic logic [31:0] wmask(input logic [1:0] s);
    return (s == 2'd0) ? 32'h0000_00FF : (s == 2'd1) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
  endfunction

  assign mem_ack   = mem_req & ack_gate;
  assign mem_rdata = mdl(mem_addr);

  dma_ctrl dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .ext_req(ext_req), .ext_ack(ext_ack), .irq(irq),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .bus_busy(bus_busy), .bus_ch(bus_ch)
  );

  // bus monitor, sampled mid-cycle
  int          wr_total = 0;
  int          rises    = 0;
  int          acks     = 0;
  logic        prev_req = 1'b0;
  logic [31:0] last_rd  = '0;
  logic [31:0] log_wa [64];
  logic [31:0] log_wd [64];
  logic [31:0] log_ra [64];
  logic [1:0]  log_ch [64];
  logic [1:0]  log_sz [64];

  always @(negedge clk) begin
    if (!rst) begin
      if (mem_req && !prev_req) rises = rises + 1;
      prev_req = mem_req;
      acks = acks + $countones(ext_ack);
      if (mem_req && !mem_we && mem_ack) last_rd = mem_addr;
      if (mem_req && mem_we && mem_ack) begin
        log_wa[wr_total % 64] = mem_addr;
        log_wd[wr_total % 64] = mem_wdata;
        log_ra[wr_total % 64] = last_rd;
        log_ch[wr_total % 64] = bus_ch;
        log_sz[wr_total % 64] = mem_size;
        wr_total = wr_total + 1;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp_v);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp_v);
    end
  endtask

  task automatic reg_write(input logic [1:0] ch, input logic [1:0] idx, input logic [31:0] d);
    @(negedge clk);
    reg_wr    = 1'b1;
    reg_addr  = {1'b0, ch, idx};
    reg_wdata = d;
    @(negedge clk);
    reg_wr    = 1'b0;
  endtask

  task automatic glob_write(input logic [31:0] d);
    @(negedge clk);
    reg_wr    = 1'b1;
    reg_addr  = 5'b10000;
    reg_wdata = d;
    @(negedge clk);
    reg_wr    = 1'b0;
  endtask

  task automatic reg_read(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic wait_irq(input logic [3:0] m, input int limit);
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if ((irq & m) == m) break;
    end
  endtask

  task automatic run_vec(input int v);
    logic [1:0]  ch, sz;
    logic        sh, dh, bst;
    logic [15:0] cnt;
    logic [31:0] src, dst, inc, rd, es, ed;
    int          w0, r0, n, k;
    {ch, sz, sh, dh, bst, cnt, src, dst} = VEC[v];
    n   = int'(cnt);
    inc = 32'd1 << sz;
    w0  = wr_total;
    r0  = rises;
    reg_write(ch, 2'd0, src);
    reg_write(ch, 2'd1, dst);
    reg_write(ch, 2'd2, {16'd0, cnt});
    reg_write(ch, 2'd3, {23'd0, 1'b1, dh, sh, sz, bst, 1'b0, 1'b1, 1'b1});
    wait_irq(4'b0001 << ch, 500);
    repeat (3) @(negedge clk);
    check(wr_total - w0 == n, "R6 unit count", 64'(wr_total - w0), 64'(n));
    check(rises - r0 == (bst ? 1 : n), "R10 bus hold pattern", 64'(rises - r0), 64'(bst ? 1 : n));
    check(irq[ch] == 1'b1, "R7 irq raised", 64'(irq[ch]), 64'd1);
    for (int i = 0; i < n; i++) begin
      k  = (w0 + i) % 64;
      es = src + (sh ? 32'd0 : inc * 32'(i));
      ed = dst + (dh ? 32'd0 : inc * 32'(i));
      check(log_ra[k] == es, sh ? "R5 source held" : "R4 source step", 64'(log_ra[k]), 64'(es));
      check(log_wa[k] == ed, dh ? "R5 dest held" : "R4 dest step", 64'(log_wa[k]), 64'(ed));
      check(log_wd[k] == (mdl(es) & wmask(sz)), "R3 write data", 64'(log_wd[k]), 64'(mdl(es) & wmask(sz)));
      check(log_sz[k] == sz, "R3 size code", 64'(log_sz[k]), 64'(sz));
      check(log_ch[k] == ch, "R2 serving channel", 64'(log_ch[k]), 64'(ch));
    end
    reg_read({1'b0, ch, 2'd3}, rd);
    check(rd[9:0] == {1'b1, 1'b1, dh, sh, sz, bst, 3'b000}, "R7 ctrl after done",
          64'(rd[9:0]), 64'({1'b1, 1'b1, dh, sh, sz, bst, 3'b000}));
    reg_write(ch, 2'd3, 32'h200);
    repeat (2) @(negedge clk);
    check(irq[ch] == 1'b0, "R7 irq cleared", 64'(irq[ch]), 64'd0);
  endtask

  task automatic order_test(input bit rr);
    int          w0, a0, c1;
    logic [1:0]  s;
    glob_write({31'd0, rr});
    for (int c = 1; c <= 2; c++) begin
      reg_write(2'(c), 2'd0, 32'h0001_0000 + 32'(c) * 32'h100);
      reg_write(2'(c), 2'd1, 32'h0002_0000 + 32'(c) * 32'h100);
      reg_write(2'(c), 2'd2, 32'd3);
      reg_write(2'(c), 2'd3, 32'h0000_0125);
    end
    w0 = wr_total;
    a0 = acks;
    @(negedge clk);
    ext_req = 4'b0110;
    wait_irq(4'b0110, 500);
    ext_req = 4'b0000;
    repeat (2) @(negedge clk);
    check(wr_total - w0 == 6, "R8 R9 total units", 64'(wr_total - w0), 64'd6);
    check(acks - a0 == 6, "R11 ack pulses", 64'(acks - a0), 64'd6);
    c1 = 0;
    for (int i = 0; i < 6; i++) begin
      s = log_ch[(w0 + i) % 64];
      if (s == 2'd1) c1++;
      if (!rr) begin
        check(s == ((i < 3) ? 2'd1 : 2'd2), "R8 fixed order", 64'(s), 64'((i < 3) ? 1 : 2));
      end else if (i > 0) begin
        check(s != log_ch[(w0 + i - 1) % 64], "R9 rotation alternates", 64'(s),
              64'(log_ch[(w0 + i - 1) % 64] ^ 2'b11));
      end
    end
    check(c1 == 3, rr ? "R9 share" : "R8 share", 64'(c1), 64'd3);
    reg_write(2'd1, 2'd3, 32'h200);
    reg_write(2'd2, 2'd3, 32'h200);
  endtask

  initial begin : watchdog
    repeat (WD_CYC) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=done", WD_CYC);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    logic [31:0] rd;
    int          w0, a0, r0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check(mem_req == 1'b0 && bus_busy == 1'b0, "R1 bus idle", 64'({mem_req, bus_busy}), 64'd0);
    check(irq == 4'd0 && ext_ack == 4'd0, "R1 irq and ack low", 64'({irq, ext_ack}), 64'd0);
    reg_read(5'b00000, rd);
    check(rd == 32'd0, "R1 src reset", 64'(rd), 64'd0);
    reg_read(5'b01110, rd);
    check(rd == 32'd0, "R1 count reset", 64'(rd), 64'd0);
    reg_read(5'b01111, rd);
    check(rd == 32'd0, "R1 ctrl reset", 64'(rd), 64'd0);
    reg_read(5'b10000, rd);
    check(rd == 32'd0, "R1 rotation reset", 64'(rd), 64'd0);

    // table of transfers: R2 R3 R4 R5 R6 R7 R10
    for (int v = 0; v < NV; v++) run_vec(v);

    // R7 masked interrupt, sticky done, write-one-to-clear
    reg_write(2'd1, 2'd0, 32'h0000_D000);
    reg_write(2'd1, 2'd1, 32'h0000_E000);
    reg_write(2'd1, 2'd2, 32'd2);
    reg_write(2'd1, 2'd3, 32'h0000_0023);
    repeat (20) @(negedge clk);
    check(irq[1] == 1'b0, "R7 masked irq stays low", 64'(irq[1]), 64'd0);
    reg_read(5'b00111, rd);
    check(rd[9:0] == 10'h220, "R7 done set, enable and go cleared", 64'(rd[9:0]), 64'h220);
    reg_write(2'd1, 2'd3, 32'h200);
    reg_read(5'b00111, rd);
    check(rd[9] == 1'b0, "R7 done cleared by write one", 64'(rd[9]), 64'd0);

    // R11 level-sensitive external trigger
    reg_write(2'd2, 2'd0, 32'h0000_F000);
    reg_write(2'd2, 2'd1, 32'h0001_F000);
    reg_write(2'd2, 2'd2, 32'd4);
    reg_write(2'd2, 2'd3, 32'h0000_011D);
    w0 = wr_total;
    a0 = acks;
    r0 = rises;
    repeat (20) @(negedge clk);
    check(wr_total == w0, "R11 no transfer while request low", 64'(wr_total - w0), 64'd0);
    reg_read(5'b01011, rd);
    check(rd[0] == 1'b1, "R11 channel still armed", 64'(rd[0]), 64'd1);
    ext_req[2] = 1'b1;
    wait_irq(4'b0100, 200);
    ext_req[2] = 1'b0;
    repeat (2) @(negedge clk);
    check(wr_total - w0 == 4, "R11 units moved", 64'(wr_total - w0), 64'd4);
    check(acks - a0 == 4, "R11 one ack per unit", 64'(acks - a0), 64'd4);
    check(rises - r0 == 1, "R10 burst while request held", 64'(rises - r0), 64'd1);
    reg_write(2'd2, 2'd3, 32'h200);

    // R8 and R9 arbitration with two live requesters in cycle-steal mode
    order_test(1'b0);
    order_test(1'b1);
    glob_write(32'd0);

    // R12 stalled bus keeps the request stable
    ack_gate = 1'b0;
    reg_write(2'd3, 2'd0, 32'h0000_7000);
    reg_write(2'd3, 2'd1, 32'h0000_7800);
    reg_write(2'd3, 2'd2, 32'd1);
    reg_write(2'd3, 2'd3, 32'h0000_0123);
    w0 = wr_total;
    repeat (6) @(negedge clk);
    check(mem_req == 1'b1 && mem_we == 1'b0, "R12 read held", 64'({mem_req, mem_we}), 64'h2);
    check(mem_addr == 32'h0000_7000, "R12 address held", 64'(mem_addr), 64'h7000);
    check(wr_total == w0, "R12 no write before ack", 64'(wr_total - w0), 64'd0);
    ack_gate = 1'b1;
    wait_irq(4'b1000, 100);
    repeat (2) @(negedge clk);
    check(wr_total - w0 == 1, "R12 unit completes after ack", 64'(wr_total - w0), 64'd1);
    reg_write(2'd3, 2'd3, 32'h200);

    // R6 zero count means 65536 units
    reg_write(2'd0, 2'd0, 32'h0010_0000);
    reg_write(2'd0, 2'd1, 32'h0020_0000);
    reg_write(2'd0, 2'd2, 32'd0);
    reg_read(5'b00010, rd);
    check(rd == 32'd0, "R6 zero count reads back zero", 64'(rd), 64'd0);
    w0 = wr_total;
    reg_write(2'd0, 2'd3, 32'h0000_012B);
    wait_irq(4'b0001, 140000);
    repeat (2) @(negedge clk);
    check(wr_total - w0 == 65536, "R6 full wrap count", 64'(wr_total - w0), 64'd65536);
    check(log_wa[(w0 + 65535) % 64] == 32'h0020_0000 + 32'd65535 * 32'd4, "R6 last destination",
          64'(log_wa[(w0 + 65535) % 64]), 64'(32'h0020_0000 + 32'd65535 * 32'd4));

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule